// File: doc/BRIEF.md
# Three-Source Vectored Interrupt Controller

This block is the interrupt logic of a small 8-bit microcontroller. It serves three interrupt sources: an external input line, where a high-to-low transition is the event, and two timer overflow pulses. A single control register, reached through the CPU's data read/write port, holds a master enable, one enable per source and one request flag per source. The block captures each event into its flag, even while the source or the master enable is off. When the master enable is set and at least one enabled flag is pending, it asks the CPU for an interrupt call to that source's fixed vector.

The request is held off while the CPU reports that its hardware return stack is full. The pending flag is kept until the stack has room. When the CPU acknowledges a call, the block clears the master enable and the flag of the source it served, so interrupts do not nest. A return-from-interrupt strobe sets the master enable again. A plain return strobe leaves it as it is. A wake-up output tells the sleep logic that an enabled request is pending. Pushing the program counter is done by the CPU and is not part of this block.

Top module: `irq_vec_ctrl`

## Requirements
- R1: The control register sits at address `CTRL_ADDR` (default 0x0B). Its bits are: 0 master enable, 1 external enable, 2 timer-0 enable, 3 timer-1 enable, 4 external flag, 5 timer-0 flag, 6 timer-1 flag. Bit 7 always reads 0. A read of any other address returns 0, and every bit is 0 after reset.
- R2: A 1-to-0 transition of `ext_line` between two clock edges sets bit 4 at the second edge. A 0-to-1 transition or a steady level does not set it.
- R3: A high `tmr0_ovf` at a clock edge sets bit 5, and a high `tmr1_ovf` sets bit 6.
- R4: Events set their flags even when the master enable or the source enable is clear.
- R5: `irq_req` is registered. It is 1 after an edge at which the master enable was set, some flag was set together with its enable, `stack_full` was low and `irq_ack` was low. `irq_vec` then gives 0x04 for external, 0x08 for timer 0 and 0x0C for timer 1. It gives 0 when nothing is pending.
- R6: When several enabled flags are pending, the external source wins, then timer 0, then timer 1.
- R7: While `stack_full` is high, `irq_req` is 0 from the next cycle on. The flags are kept.
- R8: `irq_ack` high at an edge clears the master enable and the flag of the source named by `irq_vec`. `irq_req` is 0 in the next cycle.
- R9: `reti_strobe` sets the master enable. `ret_strobe` leaves it unchanged.
- R10: `wake` is 1 whenever some flag is set together with its enable, whatever the master enable and `stack_full` are.
- R11: A write sets or clears flags and enables. A hardware event for a flag in the same cycle wins over the write for that flag. For the master enable, an acknowledge wins over the return-from-interrupt strobe, and that strobe wins over a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | CPU data address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data (control register or 0) |
| ext_line | input | 1 | External interrupt line, falling-edge event |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| stack_full | input | 1 | Return stack has no free slot |
| irq_req | output | 1 | Interrupt call request |
| irq_vec | output | VEC_W | Vector address of the requested call |
| irq_ack | input | 1 | CPU takes the requested call |
| ret_strobe | input | 1 | Plain return executed |
| reti_strobe | input | 1 | Return-from-interrupt executed |
| wake | output | 1 | Enabled request pending |

## Verification
The assertions check, on every cycle, the rules that need only one step of history. A request never follows a stack-full cycle or an acknowledge cycle. An acknowledge always drops the master enable, and the return-from-interrupt strobe always raises it. A plain return never changes it. A hardware event always leaves its flag set, and bit 7 never reads as 1. Other behaviours depend on a sequence of events, and only the bench scenarios can show them. These are the edge-polarity choice on the external line and the priority among several pending sources. They also include a pending flag surviving a stack-full period until the request appears later, and the same-cycle races between writes and events, which the random run compares against a cycle model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_SRC    = 3;
  localparam int EMI_BIT  = 0;
  localparam int EN_LSB   = 1;
  localparam int FLAG_LSB = EN_LSB + N_SRC;
  typedef logic [N_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_fall_detect.sv
module irq_fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic line,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= line;
  end

  assign fall = prev_q & ~line;
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  input  src_vec_t          hw_evt,
  input  logic              ack,
  input  src_vec_t          served,
  input  logic              reti,
  input  logic              ret,
  output logic              emi,
  output src_vec_t          en,
  output src_vec_t          flag
);
  always_ff @(posedge clk) begin
    if (rst)           emi <= 1'b0;
    else if (ack)      emi <= 1'b0;
    else if (reti)     emi <= 1'b1;
    else if (wr_hit)   emi <= wdata[EMI_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst)         en <= '0;
    else if (wr_hit) en <= wdata[EN_LSB +: N_SRC];
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                    flag[g] <= 1'b0;
      else if (hw_evt[g])         flag[g] <= 1'b1;
      else if (ack && served[g])  flag[g] <= 1'b0;
      else if (wr_hit)            flag[g] <= wdata[FLAG_LSB + g];
    end

    // R11 / R2 / R3: an event always leaves its flag set
    a_r11_event_sets_flag: assert property (@(posedge clk) disable iff (rst)
      hw_evt[g] |=> flag[g]);
  end

  a_r8_ack_clears_emi: assert property (@(posedge clk) disable iff (rst)
    ack |=> !emi);

  a_r9_reti_sets_emi: assert property (@(posedge clk) disable iff (rst)
    (reti && !ack) |=> emi);

  a_r9_ret_keeps_emi: assert property (@(posedge clk) disable iff (rst)
    (ret && !reti && !ack && !wr_hit) |=> (emi == $past(emi)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 4,
  parameter int VEC_STRIDE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             emi,
  input  src_vec_t         en,
  input  src_vec_t         flag,
  input  logic             stack_full,
  input  logic             ack,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output src_vec_t         served
);
  src_vec_t         pend;
  src_vec_t         grant;
  logic             any;
  logic [VEC_W-1:0] vec_d;

  assign pend = flag & en;

  always_comb begin
    grant = '0;
    any   = 1'b0;
    vec_d = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend[i] && !any) begin
        grant[i] = 1'b1;
        any      = 1'b1;
        vec_d    = VEC_W'(VEC_BASE + i * VEC_STRIDE);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      served  <= '0;
    end else begin
      irq_req <= emi & any & ~stack_full & ~ack;
      irq_vec <= vec_d;
      served  <= grant;
    end
  end

  a_r7_stack_hold: assert property (@(posedge clk) disable iff (rst)
    stack_full |=> !irq_req);

  a_r8_no_req_after_ack: assert property (@(posedge clk) disable iff (rst)
    ack |=> !irq_req);

  a_r5_vec_valid: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec != '0));

  a_r6_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(served));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  CTRL_ADDR  = 8'h0B,
  parameter int          VEC_W      = 8,
  parameter int          VEC_BASE   = 4,
  parameter int          VEC_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_line,
  input  logic              tmr0_ovf,
  input  logic              tmr1_ovf,
  input  logic              stack_full,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_ack,
  input  logic              ret_strobe,
  input  logic              reti_strobe,
  output logic              wake
);
  logic     addr_hit;
  logic     wr_hit;
  logic     ext_fall;
  src_vec_t hw_evt;
  src_vec_t served;
  src_vec_t en;
  src_vec_t flag;
  logic     emi;

  assign addr_hit = (reg_addr == ADDR_W'(CTRL_ADDR));
  assign wr_hit   = reg_wr & addr_hit;
  assign hw_evt   = {tmr1_ovf, tmr0_ovf, ext_fall};

  irq_fall_detect u_fall (
    .clk  (clk),
    .rst  (rst),
    .line (ext_line),
    .fall (ext_fall)
  );

  irq_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_hit (wr_hit),
    .wdata  (reg_wdata),
    .hw_evt (hw_evt),
    .ack    (irq_ack),
    .served (served),
    .reti   (reti_strobe),
    .ret    (ret_strobe),
    .emi    (emi),
    .en     (en),
    .flag   (flag)
  );

  irq_arbiter #(
    .VEC_W      (VEC_W),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
  ) u_arb (
    .clk        (clk),
    .rst        (rst),
    .emi        (emi),
    .en         (en),
    .flag       (flag),
    .stack_full (stack_full),
    .ack        (irq_ack),
    .irq_req    (irq_req),
    .irq_vec    (irq_vec),
    .served     (served)
  );

  always_comb begin
    reg_rdata = '0;
    if (addr_hit) begin
      reg_rdata[EMI_BIT]             = emi;
      reg_rdata[EN_LSB +: N_SRC]     = en;
      reg_rdata[FLAG_LSB +: N_SRC]   = flag;
    end
  end

  assign wake = |(flag & en);

  a_r1_bit7_zero: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[7] == 1'b0);
endmodule

// File: tb/irq_vec_ctrl_test.sv
`timescale 1ns/1ps
module irq_vec_ctrl_test;
  localparam logic [7:0] CTRL = 8'h0B;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] reg_addr = CTRL;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ext_line = 1'b1;
  logic       tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, stack_full = 1'b0;
  logic       irq_req;
  logic [7:0] irq_vec;
  logic       irq_ack = 1'b0, ret_strobe = 1'b0, reti_strobe = 1'b0;
  logic       wake;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model state
  logic       m_emi, m_prev, m_req;
  logic [2:0] m_en, m_flag;
  logic [7:0] m_vec;

  always #5 clk = ~clk;

  irq_vec_ctrl uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_line(ext_line),
    .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .stack_full(stack_full),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack),
    .ret_strobe(ret_strobe), .reti_strobe(reti_strobe), .wake(wake)
  );

  function automatic logic [7:0] f_vec(input logic [2:0] p);
    if (p[0]) return 8'h04;
    if (p[1]) return 8'h08;
    if (p[2]) return 8'h0C;
    return 8'h00;
  endfunction

  function automatic logic [7:0] f_rd(input logic [7:0] a);
    return (a == CTRL) ? {1'b0, m_flag, m_en, m_emi} : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic [2:0] ev, nf, pend, srv;
    logic       hit;
    if (rst) begin
      m_emi = 0; m_prev = 1; m_req = 0; m_en = 0; m_flag = 0; m_vec = 0;
      return;
    end
    hit  = reg_wr && (reg_addr == CTRL);
    ev   = {tmr1_ovf, tmr0_ovf, m_prev & ~ext_line};
    pend = m_flag & m_en;
    srv  = (m_vec == 8'h04) ? 3'b001 : (m_vec == 8'h08) ? 3'b010 :
           (m_vec == 8'h0C) ? 3'b100 : 3'b000;
    for (int i = 0; i < 3; i++) begin
      if (ev[i])                   nf[i] = 1'b1;
      else if (irq_ack && srv[i])  nf[i] = 1'b0;
      else if (hit)                nf[i] = reg_wdata[4+i];
      else                         nf[i] = m_flag[i];
    end
    m_req  = m_emi && (pend != 0) && !stack_full && !irq_ack;
    m_vec  = f_vec(pend);
    if (irq_ack)          m_emi = 1'b0;
    else if (reti_strobe) m_emi = 1'b1;
    else if (hit)         m_emi = reg_wdata[0];
    if (hit) m_en = reg_wdata[3:1];
    m_flag = nf;
    m_prev = ext_line;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R1 R11 rdata", reg_rdata, f_rd(reg_addr));
    chk("R5 R7 R8 req", {7'd0, irq_req}, {7'd0, m_req});
    chk("R5 R6 vec", irq_vec, m_vec);
    chk("R10 wake", {7'd0, wake}, {7'd0, |(m_flag & m_en)});
  endtask

  task automatic quiet();
    reg_wr = 0; reg_addr = CTRL; tmr0_ovf = 0; tmr1_ovf = 0;
    irq_ack = 0; ret_strobe = 0; reti_strobe = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1; reg_wdata = d; tick(); reg_wr = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    m_emi = 0; m_prev = 1; m_req = 0; m_en = 0; m_flag = 0; m_vec = 0;
    @(negedge clk);
    repeat (3) tick();
    rst = 0;
    @(negedge clk);
    chk("R1 reset value", reg_rdata, 8'h00);
    chk("R1 reset req", {7'd0, irq_req}, 8'h00);

    // R2 R4: falling edge with everything disabled
    ext_line = 0; tick();
    chk("R2 R4 fall sets bit4", reg_rdata, 8'h10);
    wr(8'h00);
    ext_line = 1; tick(); tick();
    chk("R2 rise ignored", reg_rdata, 8'h00);

    // R3
    tmr0_ovf = 1; tick(); tmr0_ovf = 0;
    chk("R3 tmr0 sets bit5", reg_rdata, 8'h20);
    tmr1_ovf = 1; tick(); tmr1_ovf = 0;
    chk("R3 tmr1 sets bit6", reg_rdata, 8'h60);

    // R6 R10: all pending and enabled
    wr(8'h7F);
    tick();
    chk("R6 external wins", irq_vec, 8'h04);
    chk("R5 req raised", {7'd0, irq_req}, 8'h01);
    chk("R10 wake", {7'd0, wake}, 8'h01);

    // R7: stack full holds off, flag kept
    stack_full = 1; tick(); tick();
    chk("R7 req held", {7'd0, irq_req}, 8'h00);
    chk("R7 flag kept", reg_rdata, 8'h7F);
    chk("R10 wake while full", {7'd0, wake}, 8'h01);
    stack_full = 0; tick(); tick();
    chk("R7 req after full", {7'd0, irq_req}, 8'h01);

    // R8: acknowledge
    irq_ack = 1; tick(); irq_ack = 0;
    chk("R8 ack clears emi and flag", reg_rdata, 8'h6E);
    chk("R8 req drops", {7'd0, irq_req}, 8'h00);
    tick();

    // R9
    ret_strobe = 1; tick(); ret_strobe = 0;
    chk("R9 ret leaves emi", reg_rdata, 8'h6E);
    reti_strobe = 1; tick(); reti_strobe = 0;
    chk("R9 reti sets emi", reg_rdata, 8'h6F);
    tick();
    chk("R6 timer0 next", irq_vec, 8'h08);

    // R11: write clears flags, same-cycle timer1 event wins
    tmr1_ovf = 1; wr(8'h0F); tmr1_ovf = 0;
    chk("R11 event beats write", reg_rdata, 8'h4F);

    // R1: other address reads zero
    reg_addr = 8'h0A; tick();
    chk("R1 other address", reg_rdata, 8'h00);
    reg_addr = CTRL;

    // random phase
    for (int c = 0; c < 4000; c++) begin
      quiet();
      if ($urandom_range(0, 5) == 0) ext_line = ~ext_line;
      tmr0_ovf   = ($urandom_range(0, 11) == 0);
      tmr1_ovf   = ($urandom_range(0, 11) == 0);
      stack_full = ($urandom_range(0, 7) == 0);
      if (m_req && $urandom_range(0, 1) == 0) irq_ack = 1;
      ret_strobe  = ($urandom_range(0, 15) == 0);
      reti_strobe = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 9) == 0) begin
        reg_wr = 1;
        reg_wdata = 8'($urandom);
        if ($urandom_range(0, 3) == 0) reg_addr = 8'($urandom);
      end
      tick();
    end
    quiet();
    stack_full = 0;
    tick();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule